// File: doc/BRIEF.md
# Quarter-Wave Table Numerically Controlled Oscillator

This block produces one signed sine amplitude word on every clock. An accumulator of ACC_W bits adds a programmable step word each cycle and wraps modulo 2^ACC_W, so the output frequency is step·fclk/2^ACC_W. The top PHASE_W bits of the accumulator form the phase. An optional phase offset is added to that phase before the table lookup. The lookup table holds only the first quarter of the sine. The other three quarters come from mirroring the table address and negating the result.

The two top phase bits are decoded into four named quadrants. In QD_RISE (00) the address is used as is and the sign is positive. In QD_FALL (01) the address is bit-inverted and the sign is positive. In QD_SINK (10) the address is used as is and the sign is negative. In QD_RETURN (11) the address is bit-inverted and the sign is negative. As the phase advances, the quadrant moves QD_RISE → QD_FALL → QD_SINK → QD_RETURN, and on wrap it moves QD_RETURN → QD_RISE. A large offset or step can also jump directly between any two quadrants.

A second output carries the accumulator MSB as a one-bit square wave at the programmed frequency. It is pipelined to line up with the amplitude word. The table is computed at elaboration, so the block needs no data file.

Top module: `qwave_nco`

## Requirements
- R1: A clock edge with `rst` high clears the accumulator, the held step and every pipeline register. After that edge `amp_out` is 0 and `square_out` is 0.
- R2: On each non-reset edge the accumulator adds the step modulo 2^ACC_W. The amplitude equals A(p), where p = (accumulator[ACC_W-1 -: PHASE_W] + offset) mod 2^PHASE_W. The accumulator value used is the one held before the edge that is two edges earlier than the edge that presents the output.
- R3: A new step is taken from `delta_in` only on an edge where `load` is high. On every other edge the held step is reused, and changes on `delta_in` have no effect on the outputs.
- R4: The latency is fixed at 3 clocks. A step loaded on edge k is added on edge k, and the first amplitude that reflects it appears after edge k+2. With the default parameters, loading 2^30 right after reset gives 0 after edges k and k+1 and 2047 after edge k+2.
- R5: Phase bits [PHASE_W-1:PHASE_W-2] select the quadrant. With i = p[PHASE_W-3:0], T[a] = round(AMP·sin(2π·a/2^PHASE_W)) and AMP = 2^(OUT_W-1)-1, the amplitude is: 00 gives +T[i], 01 gives +T[~i], 10 gives −T[i], 11 gives −T[~i].
- R6: For any phase p, A(p + 2^(PHASE_W-1)) = −A(p).
- R7: `offset_in` is added to the truncated phase modulo 2^PHASE_W. A value driven before edge e affects the amplitude after edge e+1. With a zero step, offsets 256, 512 and 768 give 2047, 0 and −2047.
- R8: `square_out` after edge e+1 equals the accumulator MSB held before edge e. This keeps it aligned with the amplitude path, and it ignores the offset.
- R9: A step of 2^(ACC_W-PHASE_W) gives a period of 2^PHASE_W clocks, with `square_out` high on exactly half of them. A step of 2^(ACC_W-1) makes `square_out` toggle on every clock.
- R10: `amp_out` always lies within ±AMP (±2047 by default).
- R11: Phase 0 gives amplitude 0. Phase 2^(PHASE_W-2), the start of QD_FALL, gives the table's last entry, which is 2047 by default.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Step load strobe |
| delta_in | input | ACC_W | Phase step word |
| offset_in | input | PHASE_W | Phase offset added after the accumulator |
| amp_out | output | OUT_W | Signed amplitude sample |
| square_out | output | 1 | Accumulator MSB, pipelined to match `amp_out` |

## Verification
The assertions assume that `rst` is high on the first clock edge. The sign and square properties compare against values from two edges earlier. They therefore stay silent until two non-reset edges have passed since the last reset. The bench drives every input on the falling edge, holds reset for several clocks at the start of each scenario, and raises `load` only for single cycles. A reference model in the bench predicts both outputs on every clock while the step, load and offset patterns change.

// File: rtl/nco_pkg.sv
package nco_pkg;

    typedef enum logic [1:0] {
        QD_RISE   = 2'b00,
        QD_FALL   = 2'b01,
        QD_SINK   = 2'b10,
        QD_RETURN = 2'b11
    } quadrant_t;

    // Rounded amp*sin(2*pi*idx/2^phase_w), series evaluated for the first quarter.
    function automatic int quarter_sine(input int idx, input int phase_w, input int amp);
        real x;
        real term;
        real sum;
        x    = 2.0 * 3.141592653589793 * real'(idx) / real'(1 << phase_w);
        term = x;
        sum  = x;
        for (int k = 1; k < 10; k++) begin
            term = -term * x * x / real'((2 * k) * (2 * k + 1));
            sum  = sum + term;
        end
        return $rtoi(sum * real'(amp) + 0.5);
    endfunction

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic [ACC_W-1:0]   delta_in,
    output logic [ACC_W-1:0]   delta_q,
    output logic [PHASE_W-1:0] acc_top
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] step_w;

    assign step_w = load ? delta_in : delta_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q   <= '0;
            delta_q <= '0;
        end else begin
            acc_q   <= acc_q + step_w;
            delta_q <= step_w;
        end
    end

    assign acc_top = acc_q[ACC_W-1 -: PHASE_W];

endmodule

// File: rtl/nco_quarter_lookup.sv
module nco_quarter_lookup
    import nco_pkg::*;
#(
    parameter int PHASE_W = 10,
    parameter int OUT_W   = 12
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [PHASE_W-1:0] phase_in,
    input  logic               msb_in,
    output logic [OUT_W-2:0]   mag_q,
    output logic               neg_q,
    output logic               sq_q
);

    localparam int ADDR_W = PHASE_W - 2;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int MAG_W  = OUT_W - 1;
    localparam int AMP    = (1 << (OUT_W - 1)) - 1;

    logic [MAG_W-1:0] table_w [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        localparam int VAL = quarter_sine(g, PHASE_W, AMP);
        assign table_w[g] = MAG_W'(VAL);
    end

    quadrant_t         quad_w;
    logic [ADDR_W-1:0] addr_w;
    logic              neg_w;

    assign quad_w = quadrant_t'(phase_in[PHASE_W-1 -: 2]);

    always_comb begin
        unique case (quad_w)
            QD_RISE: begin
                addr_w = phase_in[ADDR_W-1:0];
                neg_w  = 1'b0;
            end
            QD_FALL: begin
                addr_w = ~phase_in[ADDR_W-1:0];
                neg_w  = 1'b0;
            end
            QD_SINK: begin
                addr_w = phase_in[ADDR_W-1:0];
                neg_w  = 1'b1;
            end
            QD_RETURN: begin
                addr_w = ~phase_in[ADDR_W-1:0];
                neg_w  = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mag_q <= '0;
            neg_q <= 1'b0;
            sq_q  <= 1'b0;
        end else begin
            mag_q <= table_w[addr_w];
            neg_q <= neg_w;
            sq_q  <= msb_in;
        end
    end

endmodule

// File: rtl/nco_sign_stage.sv
module nco_sign_stage #(
    parameter int OUT_W = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [OUT_W-2:0]        mag_in,
    input  logic                    neg_in,
    input  logic                    sq_in,
    output logic signed [OUT_W-1:0] amp_out,
    output logic                    square_out
);

    logic signed [OUT_W-1:0] pos_w;

    assign pos_w = $signed({1'b0, mag_in});

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_out    <= '0;
            square_out <= 1'b0;
        end else begin
            amp_out    <= neg_in ? -pos_w : pos_w;
            square_out <= sq_in;
        end
    end

endmodule

// File: rtl/qwave_nco.sv
module qwave_nco #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 10,
    parameter int OUT_W   = 12
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [ACC_W-1:0]        delta_in,
    input  logic [PHASE_W-1:0]      offset_in,
    output logic signed [OUT_W-1:0] amp_out,
    output logic                    square_out
);

    logic [ACC_W-1:0]   delta_q;
    logic [PHASE_W-1:0] acc_top;
    logic [PHASE_W-1:0] phase_w;
    logic               acc_msb;
    logic [OUT_W-2:0]   mag_q;
    logic               neg_q;
    logic               sq_q;

    nco_phase_acc #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_acc (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .delta_in (delta_in),
        .delta_q  (delta_q),
        .acc_top  (acc_top)
    );

    assign phase_w = acc_top + offset_in;
    assign acc_msb = acc_top[PHASE_W-1];

    nco_quarter_lookup #(.PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_lut (
        .clk      (clk),
        .rst      (rst),
        .phase_in (phase_w),
        .msb_in   (acc_msb),
        .mag_q    (mag_q),
        .neg_q    (neg_q),
        .sq_q     (sq_q)
    );

    nco_sign_stage #(.OUT_W(OUT_W)) u_out (
        .clk        (clk),
        .rst        (rst),
        .mag_in     (mag_q),
        .neg_in     (neg_q),
        .sq_in      (sq_q),
        .amp_out    (amp_out),
        .square_out (square_out)
    );

endmodule

// File: rtl/qwave_nco_chk.sv
module qwave_nco_chk #(
    parameter int ACC_W   = 32,
    parameter int PHASE_W = 10,
    parameter int OUT_W   = 12
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    load,
    input logic [ACC_W-1:0]        delta_q,
    input logic [PHASE_W-1:0]      phase_w,
    input logic                    acc_msb,
    input logic signed [OUT_W-1:0] amp_out,
    input logic                    square_out
);

    localparam int AMP = (1 << (OUT_W - 1)) - 1;

    logic [1:0] warm  = 2'd0;
    logic       rst_d = 1'b0;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst)
            warm <= 2'd0;
        else if (warm != 2'd3)
            warm <= warm + 2'd1;
    end

    // R1: outputs cleared on the cycle after a reset edge
    always @(posedge clk) begin
        if (rst_d) begin
            a_r1_reset_clears: assert (amp_out == '0 && square_out == 1'b0)
                else $error("reset did not clear outputs");
        end
    end

    // R3: held step changes only on a load
    a_r3_hold_step: assert property (@(posedge clk) disable iff (rst)
        (!load) |=> $stable(delta_q));

    // R5: sign of a nonzero sample follows the phase MSB two edges back
    a_r5_sign_quadrant: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2 && amp_out != '0) |-> (amp_out[OUT_W-1] == $past(phase_w[PHASE_W-1], 2)));

    // R8: square output is the accumulator MSB delayed to match the amplitude path
    a_r8_square_align: assert property (@(posedge clk) disable iff (rst)
        (warm >= 2'd2) |-> (square_out == $past(acc_msb, 2)));

    // R10: amplitude stays within the table range
    a_r10_amp_bound: assert property (@(posedge clk) disable iff (rst)
        (int'(amp_out) <= AMP) && (int'(amp_out) >= -AMP));

endmodule

bind qwave_nco qwave_nco_chk #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load       (load),
    .delta_q    (delta_q),
    .phase_w    (phase_w),
    .acc_msb    (acc_msb),
    .amp_out    (amp_out),
    .square_out (square_out)
);

// File: tb/qwave_nco_test.sv
`timescale 1ns/1ps
module qwave_nco_test;

    localparam int ACC_W   = 32;
    localparam int PHASE_W = 10;
    localparam int OUT_W   = 12;
    localparam int PCOUNT  = 1 << PHASE_W;
    localparam int QSIZE   = PCOUNT / 4;
    localparam int AMP     = (1 << (OUT_W - 1)) - 1;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    load = 1'b0;
    logic [ACC_W-1:0]        delta_in = '0;
    logic [PHASE_W-1:0]      offset_in = '0;
    logic signed [OUT_W-1:0] amp_out;
    logic                    square_out;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    // reference model state
    logic [ACC_W-1:0] m_acc = '0;
    logic [ACC_W-1:0] m_step = '0;
    int               qa[$];
    int               qs[$];
    bit               model_on = 1'b0;

    qwave_nco #(.ACC_W(ACC_W), .PHASE_W(PHASE_W), .OUT_W(OUT_W)) uut (
        .clk(clk), .rst(rst), .load(load), .delta_in(delta_in),
        .offset_in(offset_in), .amp_out(amp_out), .square_out(square_out)
    );

    always #4 clk = ~clk;

    function automatic int exp_amp(int ph);
        int q   = ph / QSIZE;
        int i   = ph % QSIZE;
        int idx = (q % 2 == 1) ? (QSIZE - 1 - i) : i;
        int v   = $rtoi(real'(AMP) * $sin(2.0 * 3.141592653589793 * real'(idx) / real'(PCOUNT)) + 0.5);
        return (q >= 2) ? -v : v;
    endfunction

    task automatic check(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic model_step();
        int ph;
        if (rst) begin
            m_acc  = '0;
            m_step = '0;
            qa = {0, 0};
            qs = {0, 0};
            model_on = 1'b1;
        end else begin
            ph = (int'(m_acc[ACC_W-1 -: PHASE_W]) + int'(offset_in)) % PCOUNT;
            qa.push_back(exp_amp(ph));
            qs.push_back(int'(m_acc[ACC_W-1]));
            void'(qa.pop_front());
            void'(qs.pop_front());
            if (load) m_step = delta_in;
            m_acc = m_acc + m_step;
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        if (model_on) begin
            check(cur_req, "amp_out", int'(amp_out), qa[0]);
            check("R8", "square_out", int'(square_out), qs[0]);
            checks++;
            if (int'(amp_out) > AMP || int'(amp_out) < -AMP) begin
                errors++;
                $display("FAIL R10 amp_out out of range actual=%0d expected=within %0d", amp_out, AMP);
            end
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        load = 1'b0;
        offset_in = '0;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic load_step(logic [ACC_W-1:0] d);
        delta_in = d;
        load = 1'b1;
        tick();
        load = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        int a;
        int b;
        int highs;
        int prev;

        // R1: reset state
        cur_req = "R1";
        delta_in = 32'h1234_5678;
        do_reset();
        check("R1", "amp after reset", int'(amp_out), 0);
        check("R1", "square after reset", int'(square_out), 0);

        // R11: zero phase gives zero
        cur_req = "R11";
        load_step('0);
        repeat (4) tick();
        check("R11", "amp at phase 0", int'(amp_out), 0);

        // R4: fixed three-clock latency
        cur_req = "R4";
        do_reset();
        load_step(32'h4000_0000);
        check("R4", "amp after edge k", int'(amp_out), 0);
        tick();
        check("R4", "amp after edge k+1", int'(amp_out), 0);
        tick();
        check("R4", "amp after edge k+2", int'(amp_out), 2047);
        check("R11", "quadrant-one start peak", int'(amp_out), AMP);
        cur_req = "R2";
        repeat (20) tick();

        // R5 and R9: one table step per clock over a full cycle
        cur_req = "R5";
        do_reset();
        load_step(32'(1) << (ACC_W - PHASE_W));
        repeat (3) tick();
        highs = 0;
        for (int n = 0; n < PCOUNT; n++) begin
            tick();
            highs += int'(square_out);
        end
        check("R9", "square high count per period", highs, PCOUNT / 2);

        // R2: assorted steps loaded in single-cycle strobes
        cur_req = "R2";
        lfsr = 32'hACE1_1357;
        for (int s = 0; s < 8; s++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            lfsr = lfsr * 32'd1103515245 + 32'd12345;
            load_step(lfsr);
            repeat (150) tick();
        end

        // R3: delta_in changes without load are ignored
        cur_req = "R3";
        load_step(32'h0123_4567);
        for (int n = 0; n < 300; n++) begin
            delta_in = delta_in * 32'd69069 + 32'd1;
            tick();
        end

        // R7: phase offset with a stopped accumulator
        cur_req = "R7";
        do_reset();
        load_step('0);
        offset_in = 10'd256;
        tick();
        tick();
        check("R7", "offset 256", int'(amp_out), 2047);
        offset_in = 10'd768;
        tick();
        tick();
        check("R7", "offset 768", int'(amp_out), -2047);
        offset_in = 10'd512;
        tick();
        tick();
        check("R7", "offset 512", int'(amp_out), 0);
        load_step(32'(1) << (ACC_W - PHASE_W + 1));
        offset_in = 10'd300;
        repeat (400) tick();

        // R6: half-cycle odd symmetry
        cur_req = "R6";
        do_reset();
        load_step('0);
        for (int p = 13; p < 512; p += 97) begin
            offset_in = PHASE_W'(p);
            repeat (3) tick();
            a = int'(amp_out);
            offset_in = PHASE_W'(p + 512);
            repeat (3) tick();
            b = int'(amp_out);
            check("R6", "negated half-cycle sample", b, -a);
        end

        // R8 and R9: half-turn step toggles the square output every clock
        cur_req = "R8";
        offset_in = '0;
        load_step(32'h8000_0000);
        repeat (3) tick();
        prev = int'(square_out);
        for (int n = 0; n < 10; n++) begin
            tick();
            check("R9", "square toggles each clock", int'(square_out), 1 - prev);
            prev = int'(square_out);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule